// File: doc/BRIEF.md
# Bucket-Partitioned Receive Message Queue

This block is the receive side of one stop on an on-chip message ring. It has one shared store of 256 message slots. Software carves that store into up to eight buckets, and each bucket is a circular queue over its own contiguous slice. A message arriving from the ring names a ring-wide bucket number, from a space of 128. It carries a 64-bit payload and a 7-bit sender identity. The station accepts only the eight bucket numbers that start at its parameter `BASE_BKT`. Each accepted message lands in the slice of the matching local bucket.

A consumer removes messages one bucket at a time. Every removal returns the payload. It also raises a one-cycle credit pulse tagged with the ring bucket number and the sender that filled the slot, so that the credit can go back to that sender. Slices are laid out back to back in bucket order. A size takes effect only while every bucket is empty. A layout that cannot fit or is misaligned latches an error that stops all further intake until reset.

Top module: `msg_bucket_rx`

## Requirements
- R1: After reset, every bucket has size 0 and reports empty, not full and no overflow. `cfg_err` and `credit_ret` are 0.
- R2: Ring bucket number `BASE_BKT+i` (i from 0 to 7) addresses local bucket i. A message for any other ring number changes no flag, no content and no queue.
- R3: Writing `cfg_size` for bucket `cfg_bkt` takes effect at the next edge. Slice i starts at the sum of the sizes of buckets 0 to i-1. A bucket of size S holds exactly S messages, reports full after S accepted messages, and returns them in arrival order.
- R4: The layout is legal when every non-zero size is a power of two, every non-zero size divides its slice start, and the sizes total at most 256. Otherwise `cfg_err` rises one cycle after the write and stays set until reset. While it is set, every arriving message is dropped without raising any overflow flag.
- R5: A size write made while any bucket holds a message is ignored.
- R6: A bucket of size 0 always reports empty and never full. A message sent to it is dropped and sets that bucket's overflow flag.
- R7: A message sent to a full bucket is dropped and sets that bucket's sticky overflow flag. The stored contents are unchanged. Fullness is judged before a pop made in the same cycle.
- R8: A pop of a non-empty bucket raises `credit_ret` for exactly one cycle, on the next cycle. In that cycle `deq_data` and `credit_src` hold the oldest entry, and `credit_bkt` holds `BASE_BKT` plus the local bucket index. A pop of an empty bucket is ignored.
- R9: A push and a pop to the same non-empty, non-full bucket in one cycle are both honoured, and the occupancy is unchanged.
- R10: Buckets are independent. Traffic on one bucket, including repeated wrap-around of its pointers, never alters the order or content of another bucket.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Size write strobe |
| cfg_bkt | input | 3 | Local bucket whose size is written |
| cfg_size | input | 9 | New bucket size, 0 to 256 |
| in_valid | input | 1 | Ring message present |
| in_bkt | input | 7 | Ring-wide destination bucket number |
| in_src | input | 7 | Sender identity of the message |
| in_data | input | 64 | Message payload |
| pop_valid | input | 1 | Pop request |
| pop_bkt | input | 3 | Local bucket to pop |
| credit_ret | output | 1 | One-cycle credit return and dequeue valid |
| credit_bkt | output | 7 | Ring bucket number of the returned credit |
| credit_src | output | 7 | Sender that receives the credit |
| deq_data | output | 64 | Dequeued payload |
| bkt_empty | output | 8 | Per-bucket empty flags |
| bkt_full | output | 8 | Per-bucket full flags |
| bkt_ovf | output | 8 | Per-bucket sticky overflow flags |
| cfg_err | output | 1 | Sticky illegal-layout flag |

## Verification
An arriving message and a consumer pop can hit the same bucket in the same cycle. The hard cases are a bucket holding between one entry and one short of full, and a full bucket. The bench drives both operations in one cycle, in a directed burst on one bucket and in a long pseudo-random mix over all buckets. It judges the outcome against a per-bucket queue model that settles the pop against pre-cycle occupancy before the push. The check covers the popped entry, the credit tag, the unchanged occupancy and, for a full bucket, a drop with the overflow flag set.

// File: rtl/msg_bucket_rx.sv
module msg_bucket_rx #(
  parameter int DEPTH    = 256,
  parameter int NBKT     = 8,
  parameter int DATA_W   = 64,
  parameter int SRC_W    = 7,
  parameter int RID_W    = 7,
  parameter int BASE_BKT = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [$clog2(NBKT)-1:0]  cfg_bkt,
  input  logic [$clog2(DEPTH):0]   cfg_size,
  input  logic                     in_valid,
  input  logic [RID_W-1:0]         in_bkt,
  input  logic [SRC_W-1:0]         in_src,
  input  logic [DATA_W-1:0]        in_data,
  input  logic                     pop_valid,
  input  logic [$clog2(NBKT)-1:0]  pop_bkt,
  output logic                     credit_ret,
  output logic [RID_W-1:0]         credit_bkt,
  output logic [SRC_W-1:0]         credit_src,
  output logic [DATA_W-1:0]        deq_data,
  output logic [NBKT-1:0]          bkt_empty,
  output logic [NBKT-1:0]          bkt_full,
  output logic [NBKT-1:0]          bkt_ovf,
  output logic                     cfg_err
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int BW = $clog2(NBKT);
  localparam int EW = SRC_W + DATA_W;

  logic [CW-1:0] size_q [NBKT];
  logic [CW-1:0] cnt_q  [NBKT];
  logic [AW-1:0] head_q [NBKT];
  logic [AW-1:0] tail_q [NBKT];
  logic [CW:0]   base   [NBKT];
  logic [EW-1:0] mem    [DEPTH];
  logic          cfg_ok;

  always_comb begin
    logic [CW:0] acc;
    acc    = '0;
    cfg_ok = 1'b1;
    for (int i = 0; i < NBKT; i++) begin
      base[i] = acc;
      if (size_q[i] != '0) begin
        if ((size_q[i] & (size_q[i] - 1'b1)) != '0) cfg_ok = 1'b0;
        if ((acc & {1'b0, size_q[i] - 1'b1}) != '0) cfg_ok = 1'b0;
      end
      acc = acc + {1'b0, size_q[i]};
    end
    if (acc > (CW+1)'(DEPTH)) cfg_ok = 1'b0;
  end

  logic [RID_W-1:0] in_off;
  logic [BW-1:0]    in_idx;
  logic             in_hit, blocked, room, push_ok, push_drop, pop_ok, cfg_take;
  logic [AW-1:0]    waddr, raddr;

  assign in_off    = in_bkt - RID_W'(BASE_BKT);
  assign in_idx    = in_off[BW-1:0];
  assign in_hit    = in_valid && (in_off < RID_W'(NBKT));
  assign blocked   = cfg_err || !cfg_ok;
  assign room      = (size_q[in_idx] != '0) && (cnt_q[in_idx] != size_q[in_idx]);
  assign push_ok   = in_hit && !blocked && room;
  assign push_drop = in_hit && !blocked && !room;
  assign pop_ok    = pop_valid && (cnt_q[pop_bkt] != '0);
  assign cfg_take  = cfg_we && (&bkt_empty);
  assign waddr     = base[in_idx][AW-1:0] + tail_q[in_idx];
  assign raddr     = base[pop_bkt][AW-1:0] + head_q[pop_bkt];

  for (genvar g = 0; g < NBKT; g++) begin : g_flag
    assign bkt_empty[g] = (cnt_q[g] == '0);
    assign bkt_full[g]  = (size_q[g] != '0) && (cnt_q[g] == size_q[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBKT; i++) begin
        size_q[i] <= '0;
        cnt_q[i]  <= '0;
        head_q[i] <= '0;
        tail_q[i] <= '0;
      end
      bkt_ovf <= '0;
    end else begin
      for (int i = 0; i < NBKT; i++) begin
        if (push_ok && in_idx == BW'(i))
          tail_q[i] <= (tail_q[i] + 1'b1) & AW'(size_q[i] - 1'b1);
        if (pop_ok && pop_bkt == BW'(i))
          head_q[i] <= (head_q[i] + 1'b1) & AW'(size_q[i] - 1'b1);
        if ((push_ok && in_idx == BW'(i)) && !(pop_ok && pop_bkt == BW'(i)))
          cnt_q[i] <= cnt_q[i] + 1'b1;
        else if (!(push_ok && in_idx == BW'(i)) && (pop_ok && pop_bkt == BW'(i)))
          cnt_q[i] <= cnt_q[i] - 1'b1;
        if (push_drop && in_idx == BW'(i))
          bkt_ovf[i] <= 1'b1;
        if (cfg_take && cfg_bkt == BW'(i)) begin
          size_q[i] <= cfg_size;
          head_q[i] <= '0;
          tail_q[i] <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[waddr] <= {in_src, in_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      credit_ret <= 1'b0;
      credit_bkt <= '0;
      credit_src <= '0;
      deq_data   <= '0;
      cfg_err    <= 1'b0;
    end else begin
      credit_ret <= pop_ok;
      cfg_err    <= cfg_err || !cfg_ok;
      if (pop_ok) begin
        credit_bkt             <= RID_W'(BASE_BKT) + RID_W'(pop_bkt);
        {credit_src, deq_data} <= mem[raddr];
      end
    end
  end
endmodule

// File: rtl/msg_bucket_rx_chk.sv
module msg_bucket_rx_chk #(
  parameter int NBKT     = 8,
  parameter int RID_W    = 7,
  parameter int BASE_BKT = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [RID_W-1:0]        in_bkt,
  input logic                    pop_valid,
  input logic [$clog2(NBKT)-1:0] pop_bkt,
  input logic                    credit_ret,
  input logic [RID_W-1:0]        credit_bkt,
  input logic [NBKT-1:0]         bkt_empty,
  input logic [NBKT-1:0]         bkt_full,
  input logic [NBKT-1:0]         bkt_ovf,
  input logic                    cfg_err
);
  localparam int BW = $clog2(NBKT);

  logic [RID_W-1:0] off;
  logic [BW-1:0]    idx, idx_q;
  logic             hit;

  assign off = in_bkt - RID_W'(BASE_BKT);
  assign idx = off[BW-1:0];
  assign hit = in_valid && (off < RID_W'(NBKT));

  always_ff @(posedge clk) idx_q <= idx;

  assert_empty_full_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bkt_empty & bkt_full) == '0);

  assert_credit_after_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    credit_ret |-> $past(pop_valid && !bkt_empty[pop_bkt]));

  assert_no_credit_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop_valid || bkt_empty[pop_bkt]) |=> !credit_ret);

  assert_credit_bkt_local_R2: assert property (@(posedge clk) disable iff (!rst_n)
    credit_ret |-> ((credit_bkt - RID_W'(BASE_BKT)) < RID_W'(NBKT)));

  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bkt_ovf) & ~bkt_ovf) == '0);

  assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !cfg_err && bkt_full[idx]) |=> bkt_ovf[idx_q]);

  assert_push_pop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !cfg_err && pop_valid && pop_bkt == idx && !bkt_empty[idx] && !bkt_full[idx])
    |=> (!bkt_empty[idx_q] && !bkt_full[idx_q]));
endmodule

bind msg_bucket_rx msg_bucket_rx_chk #(
  .NBKT(NBKT), .RID_W(RID_W), .BASE_BKT(BASE_BKT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bkt(in_bkt),
  .pop_valid(pop_valid), .pop_bkt(pop_bkt), .credit_ret(credit_ret),
  .credit_bkt(credit_bkt), .bkt_empty(bkt_empty), .bkt_full(bkt_full),
  .bkt_ovf(bkt_ovf), .cfg_err(cfg_err)
);

// File: tb/msg_bucket_rx_tb_top.sv
module msg_bucket_rx_tb_top;
  localparam int NB = 8;
  localparam int BASEB = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_bkt = '0;
  logic [8:0]  cfg_size = '0;
  logic        in_valid = 1'b0;
  logic [6:0]  in_bkt = '0;
  logic [6:0]  in_src = '0;
  logic [63:0] in_data = '0;
  logic        pop_valid = 1'b0;
  logic [2:0]  pop_bkt = '0;
  logic        credit_ret;
  logic [6:0]  credit_bkt, credit_src;
  logic [63:0] deq_data;
  logic [NB-1:0] bkt_empty, bkt_full, bkt_ovf;
  logic        cfg_err;

  always #4 clk = ~clk;

  msg_bucket_rx dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bkt(cfg_bkt), .cfg_size(cfg_size),
    .in_valid(in_valid), .in_bkt(in_bkt), .in_src(in_src), .in_data(in_data),
    .pop_valid(pop_valid), .pop_bkt(pop_bkt), .credit_ret(credit_ret),
    .credit_bkt(credit_bkt), .credit_src(credit_src), .deq_data(deq_data),
    .bkt_empty(bkt_empty), .bkt_full(bkt_full), .bkt_ovf(bkt_ovf), .cfg_err(cfg_err)
  );

  int vecs = 0;
  int errs = 0;
  int msz[NB], mcnt[NB], mhd[NB];
  logic [70:0] mq[NB][256];
  logic [NB-1:0] movf;
  bit merr;

  function automatic bit cfg_legal();
    int acc = 0;
    for (int b = 0; b < NB; b++) begin
      if (msz[b] != 0) begin
        bit p2 = 0;
        for (int k = 0; k <= 8; k++) if (msz[b] == (1 << k)) p2 = 1;
        if (!p2) return 0;
        if ((acc % msz[b]) != 0) return 0;
      end
      acc += msz[b];
    end
    return acc <= 256;
  endfunction

  function automatic logic [63:0] mkdata(int b, int n);
    return {8'hC3, 8'(b), 16'(n), 32'(n * 32'h9E3779B1)};
  endfunction

  task automatic cmp(string req, string what, logic [127:0] act, logic [127:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_status(string req);
    logic [NB-1:0] ee, ef;
    for (int b = 0; b < NB; b++) begin
      ee[b] = (mcnt[b] == 0);
      ef[b] = (msz[b] != 0) && (mcnt[b] == msz[b]);
    end
    cmp(req, "bkt_empty", bkt_empty, ee);
    cmp(req, "bkt_full", bkt_full, ef);
    cmp(req, "bkt_ovf", bkt_ovf, movf);
    cmp(req, "cfg_err", cfg_err, merr);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; pop_valid = 1'b0; cfg_we = 1'b0;
    for (int b = 0; b < NB; b++) begin msz[b] = 0; mcnt[b] = 0; mhd[b] = 0; end
    movf = '0; merr = 0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk_status("R1");
    cmp("R1", "credit_ret", credit_ret, 0);
  endtask

  task automatic step(string req, bit pv, int rb, int src, logic [63:0] d, bit qv, int qb);
    int lb, tl;
    bit loc, apush, adrop, apop;
    logic [70:0] pent;
    @(negedge clk);
    in_valid = pv; in_bkt = 7'(rb); in_src = 7'(src); in_data = d;
    pop_valid = qv; pop_bkt = 3'(qb);
    lb = rb - BASEB;
    loc = pv && lb >= 0 && lb < NB;
    apush = 0;
    if (loc && !merr) apush = (msz[lb] != 0) && (mcnt[lb] < msz[lb]);
    adrop = loc && !merr && !apush;
    apop = qv && (mcnt[qb] > 0);
    pent = '0;
    if (apop) pent = mq[qb][mhd[qb]];
    if (apush) begin
      tl = (mhd[lb] + mcnt[lb]) % msz[lb];
      mq[lb][tl] = {7'(src), d};
      mcnt[lb]++;
    end
    if (adrop) movf[lb] = 1'b1;
    if (apop) begin
      mhd[qb] = (mhd[qb] + 1) % msz[qb];
      mcnt[qb]--;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0; pop_valid = 1'b0;
    cmp(req, "credit_ret", credit_ret, apop);
    if (apop) begin
      cmp(req, "credit_bkt", credit_bkt, BASEB + qb);
      cmp(req, "credit_src", credit_src, pent[70:64]);
      cmp(req, "deq_data", deq_data, pent[63:0]);
    end
    chk_status(req);
  endtask

  task automatic cfgw(string req, int b, int s);
    bit idle = 1;
    @(negedge clk);
    cfg_we = 1'b1; cfg_bkt = 3'(b); cfg_size = 9'(s);
    @(posedge clk);
    #1 cfg_we = 1'b0;
    @(posedge clk);
    #1;
    for (int k = 0; k < NB; k++) if (mcnt[k] != 0) idle = 0;
    if (idle) begin
      msz[b] = s; mhd[b] = 0;
      if (!cfg_legal()) merr = 1;
    end
    chk_status(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int sl[12] = '{0, 1, 2, 4, 8, 16, 32, 64, 128, 256, 3, 48};
    int unsigned r = 32'h1234_5678;
    int seq = 0;

    do_reset();
    // R6 zero-size buckets, R2 foreign bucket numbers
    step("R6", 1, BASEB + 3, 1, mkdata(3, 0), 0, 0);
    step("R2", 1, BASEB - 1, 2, mkdata(9, 1), 0, 0);
    step("R2", 1, BASEB + NB, 3, mkdata(9, 2), 0, 0);
    step("R2", 1, 127, 4, mkdata(9, 3), 0, 0);
    step("R8", 0, 0, 0, 0, 1, 2);

    do_reset();
    cfgw("R3", 0, 32);
    cfgw("R3", 1, 32);
    cfgw("R3", 2, 64);
    cfgw("R3", 3, 0);
    cfgw("R3", 4, 128);
    // fill every bucket to capacity and one beyond (R3, R7, R6)
    for (int b = 0; b < NB; b++)
      for (int n = 0; n <= msz[b]; n++)
        step(n == msz[b] ? "R7" : "R3", 1, BASEB + b, (n * 5 + b) % 128, mkdata(b, n), 0, 0);
    // pop against a full bucket while pushing: push dropped (R7)
    step("R7", 1, BASEB + 0, 77, mkdata(0, 999), 1, 0);
    // drain interleaved across buckets (R10, R8)
    for (int n = 0; n < 130; n++)
      for (int b = 0; b < 5; b++)
        step("R10", 0, 0, 0, 0, 1, b);
    step("R8", 0, 0, 0, 0, 1, 0);
    // wrap bucket 1 repeatedly (R10)
    for (int n = 0; n < 100; n++)
      step("R10", 1, BASEB + 1, n % 128, mkdata(1, 1000 + n), n >= 5, 1);
    // simultaneous push and pop on one bucket (R9)
    for (int n = 0; n < 40; n++)
      step("R9", 1, BASEB + 2, (n * 3) % 128, mkdata(2, 2000 + n), n >= 1, 2);
    // size writes while busy are ignored (R5)
    cfgw("R5", 5, 64);
    step("R5", 1, BASEB + 5, 9, mkdata(5, 1), 0, 0);
    cfgw("R5", 0, 16);
    for (int n = 0; n < 33; n++)
      step("R5", 1, BASEB + 0, 11, mkdata(0, 3000 + n), 0, 0);
    // long mixed traffic over all buckets (R9, R10, R2)
    for (int n = 0; n < 3000; n++) begin
      r = r * 32'd1103515245 + 32'd12345;
      seq++;
      step("R10", r[16] | r[17], BASEB - 2 + int'(r[27:24]) % 12, int'(r[6:0]),
           mkdata(int'(r[27:24]), seq), r[18] | r[19], int'(r[22:20]));
    end

    // layout legality sweep over two buckets (R4)
    foreach (sl[i]) foreach (sl[j]) begin
      do_reset();
      cfgw("R4", 0, sl[i]);
      cfgw("R4", 1, sl[j]);
      step("R4", 1, BASEB + 1, 5, mkdata(1, i * 16 + j), 0, 0);
      step("R4", 0, 0, 0, 0, 1, 1);
    end
    do_reset();
    cfgw("R4", 0, 128);
    cfgw("R4", 1, 128);
    cfgw("R4", 2, 256);
    step("R4", 1, BASEB + 0, 6, mkdata(0, 7), 0, 0);
    do_reset();
    cfgw("R4", 0, 256);
    cfgw("R4", 1, 1);
    step("R4", 1, BASEB + 0, 6, mkdata(0, 8), 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule